// File: doc/BRIEF.md
# Memory Device Power-State Controller

This block keeps track of which power state a single memory device is in: two low-power states (powerdown and nap), a standby state, and an attention state with separate reading and writing sub-states. Decoded row-operation strobes move the device between standby, attention and the low-power states. Column strobes move it between attention and its sub-states. A registered column-enable output tells the column datapath when column packets may be taken.

Leaving nap or powerdown is controlled only through a slow serial clock and a one-bit serial command line. Both are brought into the system clock domain through a synchronizer. A wake-up is a rising edge of the serial command bit, as seen on successive serial-clock rising edges. It is accepted when the broadcast-exit bit is set, or when the presented wake address equals the device address. The exit delay is then counted in serial-clock ticks. A powerdown exit first counts a programmed number of 64-tick units and then a programmed tick count. A nap exit counts its own programmed tick count. When the delay ends, the device goes back to standby or to attention, depending on where it entered the low-power state from.

Top module: `pwr_state_ctrl`

## Requirements
- R1: `col_en` is 1 exactly while `state` is attention (3), attention-read (4) or attention-write (5). A column strobe in standby (2) leaves the state unchanged.
- R2: In any attention state, a column strobe with `col_wr`=0 moves the state to attention-read (4). A column strobe with `col_wr`=1 moves it to attention-write (5). This includes switching directly between the two sub-states.
- R3: A sub-state returns to attention IDLE_CYC clock cycles after the last accepted column strobe. Each new column strobe restarts that count.
- R4: Row operations use `row_op` codes 0 activate, 1 relax, 2 nap and 3 powerdown. Activate moves standby to attention. Relax moves any attention state to standby. When a relax, nap or powerdown arrives in the same cycle as a column strobe, the row operation wins.
- R5: A wake-up is only a serial command bit of 1 sampled on a serial-clock rising edge when the previous sample was 0. A wake-up outside nap and powerdown has no effect.
- R6: A wake-up starts an exit only if `bcast_exit` is 1 or `wake_id` equals `dev_id`.
- R7: A powerdown exit takes `pdn_dly_a`×64 serial-clock ticks followed by `pdn_dly_b` ticks, counted after the wake-up tick. The state changes within a few clock cycles of the last tick and not before it.
- R8: A nap exit takes `nap_dly` serial-clock ticks after the wake-up tick. A value of 0 exits right after the wake-up.
- R9: At the end of an exit, the state becomes standby if the low-power state was entered from standby, and attention otherwise.
- R10: In nap or powerdown, row and column strobes do not change the state. They set `cmd_err`, which stays at 1 until reset.
- R11: After synchronous reset, `state` is standby (2), `col_en` is 0, `cmd_err` is 0 and no exit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_vld | input | 1 | Decoded row-operation strobe |
| row_op | input | 2 | Row operation code: 0 activate, 1 relax, 2 nap, 3 powerdown |
| col_vld | input | 1 | Decoded column command strobe |
| col_wr | input | 1 | Column command is a write (1) or a read (0) |
| sclk | input | 1 | Slow serial clock, asynchronous to clk |
| sio_cmd | input | 1 | Serial command bit |
| bcast_exit | input | 1 | 1: any wake-up exits; 0: address must match |
| dev_id | input | ID_W | This device's address |
| wake_id | input | ID_W | Address presented with the wake-up |
| pdn_dly_a | input | A_W | Powerdown exit first phase, in 64-tick units |
| pdn_dly_b | input | B_W | Powerdown exit second phase, in ticks |
| nap_dly | input | B_W | Nap exit delay, in ticks |
| state | output | 3 | Power state: 0 powerdown, 1 nap, 2 standby, 3 attention, 4 attention-read, 5 attention-write |
| col_en | output | 1 | Column packets may be accepted |
| cmd_err | output | 1 | Sticky flag: a command arrived during nap or powerdown |

## Verification
A wrong internal state shows at the `state` and `col_en` ports one clock cycle after the strobe that caused it. The checks therefore sample right after each command. A fault in the exit counters, such as a wrong unit length or a phase counted in the wrong order, only shows when the exit finishes. The bench checks both the tick before the expected exit and the tick that completes it. A miscounted idle timer shows as a sub-state that returns to attention one cycle early or late. Vectors placed on both sides of that edge catch it.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_PDN   = 3'd0,
    PS_NAP   = 3'd1,
    PS_STBY  = 3'd2,
    PS_ATTN  = 3'd3,
    PS_ATTNR = 3'd4,
    PS_ATTNW = 3'd5
  } pstate_e;

  typedef enum logic [1:0] {
    ROP_ACT = 2'd0,
    ROP_RLX = 2'd1,
    ROP_NAP = 2'd2,
    ROP_PDN = 2'd3
  } rop_e;

endpackage

// File: rtl/ser_wake_detect.sv
module ser_wake_detect #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic sio_cmd,
  output logic tick,
  output logic wake
);

  logic [SYNC_N-1:0] sck_s;
  logic [SYNC_N-1:0] cmd_s;
  logic              sck_last;
  logic              cmd_last;
  logic              sck_now;
  logic              cmd_now;
  logic              rise;

  // synchronizer chains for the slow serial clock and command bit
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      cmd_s <= '0;
    end else begin
      sck_s[0] <= sclk;
      cmd_s[0] <= sio_cmd;
      for (int i = 1; i < SYNC_N; i++) begin
        sck_s[i] <= sck_s[i-1];
        cmd_s[i] <= cmd_s[i-1];
      end
    end
  end

  assign sck_now = sck_s[SYNC_N-1];
  assign cmd_now = cmd_s[SYNC_N-1];
  assign rise    = sck_now & ~sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_last <= 1'b0;
      cmd_last <= 1'b0;
      tick     <= 1'b0;
      wake     <= 1'b0;
    end else begin
      sck_last <= sck_now;
      tick     <= rise;
      wake     <= rise & cmd_now & ~cmd_last;
      if (rise) cmd_last <= cmd_now;
    end
  end

  AST_WAKE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    wake |-> tick); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5

endmodule

// File: rtl/exit_timer.sv
module exit_timer #(
  parameter int A_W  = 5,
  parameter int B_W  = 8,
  parameter int UNIT = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_pdn,
  input  logic           tick,
  input  logic [A_W-1:0] dly_a,
  input  logic [B_W-1:0] dly_b,
  input  logic [B_W-1:0] dly_nap,
  output logic           busy,
  output logic           done
);

  localparam int SUB_W = (UNIT > 1) ? $clog2(UNIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT - 1);

  logic [A_W-1:0]   cnt_a;
  logic [B_W-1:0]   cnt_b;
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_a <= '0;
      cnt_b <= '0;
      sub   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_a <= is_pdn ? dly_a : '0;
      cnt_b <= is_pdn ? dly_b : dly_nap;
      sub   <= '0;
    end else if (busy) begin
      if (cnt_a == '0 && cnt_b == '0) begin
        busy <= 1'b0;
      end else if (tick) begin
        if (cnt_a != '0) begin
          if (sub == SUB_LAST) begin
            sub   <= '0;
            cnt_a <= cnt_a - 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end else begin
          cnt_b <= cnt_b - 1'b1;
        end
      end
    end
  end

  assign done = busy && (cnt_a == '0) && (cnt_b == '0);

  // second phase never advances while the first still runs
  AST_PHASE_A_FIRST: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_a != '0 && !start) |=> $stable(cnt_b)); // R7

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !busy); // R8

  AST_SUB_IDLE_PHASE_B: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_a == '0 && !start) |=> $stable(sub)); // R7

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter int IDLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       row_vld,
  input  logic [1:0] row_op,
  input  logic       col_vld,
  input  logic       col_wr,
  input  logic       wake,
  input  logic       wake_sel,
  input  logic       tmr_busy,
  input  logic       tmr_done,
  output pstate_e    state_q,
  output logic       col_en_q,
  output logic       err_q,
  output logic       tmr_start,
  output logic       tmr_pdn
);

  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYC - 1);

  pstate_e           nxt;
  pstate_e           ret_q;
  pstate_e           ret_d;
  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W-1:0] idle_d;
  logic              err_d;
  logic              low;
  logic              attn_any;
  logic              nxt_attn;
  logic              col_ok;
  rop_e              op;

  assign op       = rop_e'(row_op);
  assign low      = (state_q == PS_NAP) || (state_q == PS_PDN);
  assign attn_any = (state_q == PS_ATTN) || (state_q == PS_ATTNR) || (state_q == PS_ATTNW);
  assign col_ok   = col_vld && col_en_q;

  always_comb begin
    nxt       = state_q;
    ret_d     = ret_q;
    idle_d    = idle_q;
    err_d     = err_q;
    tmr_start = 1'b0;
    tmr_pdn   = 1'b0;
    if (low) begin
      if (row_vld || col_vld) err_d = 1'b1;
      if (tmr_done) begin
        nxt = ret_q;
      end else if (wake && wake_sel && !tmr_busy) begin
        tmr_start = 1'b1;
        tmr_pdn   = (state_q == PS_PDN);
      end
    end else begin
      if (row_vld && (op == ROP_NAP || op == ROP_PDN)) begin
        nxt   = (op == ROP_NAP) ? PS_NAP : PS_PDN;
        ret_d = attn_any ? PS_ATTN : PS_STBY;
      end else if (row_vld && op == ROP_RLX) begin
        nxt = PS_STBY;
      end else if (row_vld && op == ROP_ACT && state_q == PS_STBY) begin
        nxt = PS_ATTN;
      end else if (col_ok) begin
        nxt    = col_wr ? PS_ATTNW : PS_ATTNR;
        idle_d = '0;
      end else if (state_q == PS_ATTNR || state_q == PS_ATTNW) begin
        if (idle_q == IDLE_LAST) nxt = PS_ATTN;
        else idle_d = idle_q + 1'b1;
      end
    end
  end

  assign nxt_attn = (nxt == PS_ATTN) || (nxt == PS_ATTNR) || (nxt == PS_ATTNW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_STBY;
      ret_q    <= PS_STBY;
      idle_q   <= '0;
      err_q    <= 1'b0;
      col_en_q <= 1'b0;
    end else begin
      state_q  <= nxt;
      ret_q    <= ret_d;
      idle_q   <= idle_d;
      err_q    <= err_d;
      col_en_q <= nxt_attn;
    end
  end

  AST_COLEN_TRACK: assert property (@(posedge clk) disable iff (rst)
    col_en_q == (state_q inside {PS_ATTN, PS_ATTNR, PS_ATTNW})); // R1

  AST_STBY_COL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_STBY && !row_vld) |=> state_q == PS_STBY); // R1

  AST_RD_TO_ATTNR: assert property (@(posedge clk) disable iff (rst)
    (attn_any && col_vld && !col_wr && !row_vld) |=> state_q == PS_ATTNR); // R2

  AST_WR_TO_ATTNW: assert property (@(posedge clk) disable iff (rst)
    (attn_any && col_vld && col_wr && !row_vld) |=> state_q == PS_ATTNW); // R2

  AST_SUB_IDLE_PATH: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_ATTNR && !col_vld && !row_vld) |=> state_q inside {PS_ATTNR, PS_ATTN}); // R3

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (low && !tmr_done) |=> state_q == $past(state_q)); // R10

  AST_LOW_CMD_ERR: assert property (@(posedge clk) disable iff (rst)
    (low && (row_vld || col_vld)) |=> err_q); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R10

  AST_EXIT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (low && tmr_done) |=> state_q inside {PS_STBY, PS_ATTN}); // R9

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int ID_W     = 6,
  parameter int A_W      = 5,
  parameter int B_W      = 8,
  parameter int UNIT     = 64,
  parameter int IDLE_CYC = 4,
  parameter int SYNC_N   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            row_vld,
  input  logic [1:0]      row_op,
  input  logic            col_vld,
  input  logic            col_wr,
  input  logic            sclk,
  input  logic            sio_cmd,
  input  logic            bcast_exit,
  input  logic [ID_W-1:0] dev_id,
  input  logic [ID_W-1:0] wake_id,
  input  logic [A_W-1:0]  pdn_dly_a,
  input  logic [B_W-1:0]  pdn_dly_b,
  input  logic [B_W-1:0]  nap_dly,
  output logic [2:0]      state,
  output logic            col_en,
  output logic            cmd_err
);

  logic    tick;
  logic    wake;
  logic    wake_sel;
  logic    tmr_busy;
  logic    tmr_done;
  logic    tmr_start;
  logic    tmr_pdn;
  pstate_e st;

  assign wake_sel = bcast_exit || (wake_id == dev_id);

  ser_wake_detect #(.SYNC_N(SYNC_N)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .sclk    (sclk),
    .sio_cmd (sio_cmd),
    .tick    (tick),
    .wake    (wake)
  );

  exit_timer #(.A_W(A_W), .B_W(B_W), .UNIT(UNIT)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .is_pdn  (tmr_pdn),
    .tick    (tick),
    .dly_a   (pdn_dly_a),
    .dly_b   (pdn_dly_b),
    .dly_nap (nap_dly),
    .busy    (tmr_busy),
    .done    (tmr_done)
  );

  pwr_state_fsm #(.IDLE_CYC(IDLE_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .row_vld   (row_vld),
    .row_op    (row_op),
    .col_vld   (col_vld),
    .col_wr    (col_wr),
    .wake      (wake),
    .wake_sel  (wake_sel),
    .tmr_busy  (tmr_busy),
    .tmr_done  (tmr_done),
    .state_q   (st),
    .col_en_q  (col_en),
    .err_q     (cmd_err),
    .tmr_start (tmr_start),
    .tmr_pdn   (tmr_pdn)
  );

  assign state = 3'(st);

endmodule

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       row_vld = 1'b0;
  logic [1:0] row_op = 2'd0;
  logic       col_vld = 1'b0;
  logic       col_wr = 1'b0;
  logic       sclk = 1'b0;
  logic       sio_cmd = 1'b0;
  logic       bcast_exit = 1'b0;
  logic [5:0] dev_id = 6'd21;
  logic [5:0] wake_id = 6'd21;
  logic [4:0] pdn_dly_a = 5'd1;
  logic [7:0] pdn_dly_b = 8'd2;
  logic [7:0] nap_dly = 8'd3;
  logic [2:0] state;
  logic       col_en;
  logic       cmd_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwr_state_ctrl #(.IDLE_CYC(4)) u0 (
    .clk(clk), .rst(rst), .row_vld(row_vld), .row_op(row_op),
    .col_vld(col_vld), .col_wr(col_wr), .sclk(sclk), .sio_cmd(sio_cmd),
    .bcast_exit(bcast_exit), .dev_id(dev_id), .wake_id(wake_id),
    .pdn_dly_a(pdn_dly_a), .pdn_dly_b(pdn_dly_b), .nap_dly(nap_dly),
    .state(state), .col_en(col_en), .cmd_err(cmd_err)
  );

  typedef struct packed {
    logic       rv;
    logic [1:0] op;
    logic       cv;
    logic       cw;
    logic [2:0] st;
    logic       ce;
    logic       er;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd1},
    '{1'b1, 2'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd4},
    '{1'b0, 2'd0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 4'd2},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd3},
    '{1'b1, 2'd1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd4},
    '{1'b1, 2'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'd0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 4'd1}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] est, input logic ece, input logic eer);
    checks++;
    if (state !== est || col_en !== ece || cmd_err !== eer) begin
      fails++;
      $display("FAIL %s: state=%0d col_en=%0b cmd_err=%0b expected state=%0d col_en=%0b cmd_err=%0b",
               req, state, col_en, cmd_err, est, ece, eer);
    end
  endtask

  task automatic do_cmd(input logic rv, input logic [1:0] op, input logic cv, input logic cw);
    row_vld = rv; row_op = op; col_vld = cv; col_wr = cw;
    @(negedge clk);
    row_vld = 1'b0; col_vld = 1'b0;
  endtask

  // one serial clock period of six system cycles, command bit set with the rise
  task automatic ser_pulse(input logic c);
    sclk = 1'b1; sio_cmd = c;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset", 3'd2, 1'b0, 1'b0);

    // table: R1 column gating, R2 sub-states, R3 idle return, R4 row ops
    for (int i = 0; i < NV; i++) begin
      row_vld = VEC[i].rv; row_op = VEC[i].op;
      col_vld = VEC[i].cv; col_wr = VEC[i].cw;
      @(negedge clk);
      check(req_name(VEC[i].rq), VEC[i].st, VEC[i].ce, VEC[i].er);
    end
    row_vld = 1'b0; col_vld = 1'b0;

    // R5: wake-up in standby has no effect
    ser_pulse(1'b1);
    check("R5 wake in standby", 3'd2, 1'b0, 1'b0);

    // enter nap from standby
    do_cmd(1'b1, 2'd2, 1'b0, 1'b0);
    check("R4 nap entry", 3'd1, 1'b0, 1'b0);

    // R10: command in nap ignored, error set
    do_cmd(1'b0, 2'd0, 1'b1, 1'b0);
    check("R10 column in nap", 3'd1, 1'b0, 1'b1);
    do_cmd(1'b1, 2'd0, 1'b0, 1'b0);
    check("R10 activate in nap", 3'd1, 1'b0, 1'b1);

    // R5: command bit stays 1, no new wake-up
    ser_pulse(1'b1);
    check("R5 no rising command bit", 3'd1, 1'b0, 1'b1);
    ser_pulse(1'b0);

    // R6: address mismatch without broadcast
    wake_id = 6'd5;
    ser_pulse(1'b1);
    check("R6 mismatched address", 3'd1, 1'b0, 1'b1);
    ser_pulse(1'b0);

    // R8: matched wake-up, nap delay of 3 ticks
    wake_id = 6'd21;
    ser_pulse(1'b1);
    ser_pulse(1'b0);
    ser_pulse(1'b0);
    check("R8 nap exit before last tick", 3'd1, 1'b0, 1'b1);
    ser_pulse(1'b0);
    check("R9 nap exit to standby", 3'd2, 1'b0, 1'b1);

    // powerdown from attention, broadcast exit with mismatched address
    do_cmd(1'b1, 2'd0, 1'b0, 1'b0);
    check("R4 activate", 3'd3, 1'b1, 1'b1);
    do_cmd(1'b1, 2'd3, 1'b0, 1'b0);
    check("R4 powerdown entry", 3'd0, 1'b0, 1'b1);
    bcast_exit = 1'b1;
    wake_id = 6'd9;
    ser_pulse(1'b1);
    for (int k = 0; k < 65; k++) ser_pulse(1'b0);
    check("R7 powerdown exit one tick early", 3'd0, 1'b0, 1'b1);
    ser_pulse(1'b0);
    check("R7 R6 powerdown exit to attention", 3'd3, 1'b1, 1'b1);

    // R8: zero nap delay
    nap_dly = 8'd0;
    do_cmd(1'b1, 2'd2, 1'b0, 1'b0);
    check("R4 nap from attention", 3'd1, 1'b0, 1'b1);
    ser_pulse(1'b1);
    check("R8 R9 zero-delay nap exit", 3'd3, 1'b1, 1'b1);

    // R11: reset clears error flag and state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset after error", 3'd2, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule